// File: doc/BRIEF.md
# Lock-Protected System Register File

This block is a bank of memory-mapped control and status registers behind a zero-wait APB-style slave port. It holds three clock-divisor words for an external clock generator. A key register guards those words, so one stray write cannot retune a clock. The bank also holds an LED drive byte, a latched push-button flag that raises an interrupt request, a switch readback byte, and a set of data and address words used by simple bus test masters.

A write commits on the clock edge where `psel`, `penable` and `pwrite` are all high. Read data is combinational from `paddr` during the access. The push-button input passes through a two-stage synchroniser and a rising-edge detector. One press therefore sets the flag once, however long the button is held.

Top module: `lockreg_file`

## Requirements
- R1: After reset each divisor word reads 0x00002C70 (post-divider 0, reference divider 22, VCO divider 112). The guard reads locked. The LED byte, button flag, interrupt, write-data word and last-read word are 0. The two address words read 0x04000000 and 0x04000004.
- R2: Writing a value whose bits [15:0] equal 0xA05F to offset 0x0C unlocks the divisor words. Writing any other value to 0x0C locks them again.
- R3: Offset 0x0C reads bit 16 as 1 when locked and 0 when unlocked. Every other bit reads 0, and no write changes bit 16 directly.
- R4: A write to a divisor word at 0x00, 0x04 or 0x08 while locked is ignored, both in readback and on `osc_cfg`.
- R5: While unlocked, a divisor write stores bits [18:0], whose fields are post-divider [18:16], reference divider [15:9] and VCO divider [8:0]. Bits [31:19] read 0. Word i drives `osc_cfg[19*i+18:19*i]`.
- R6: The byte at 0x10 is read/write and drives `led_out`. A 1 in a bit lights that LED.
- R7: A rising edge of `btn_in` sets the flag, readable at 0x18 bit 0 and driven on `irq_out`, on the third clock edge after the input changes. Holding the button sets the flag only once.
- R8: Writing 0 to 0x18 bit 0 clears the flag, and writing 1 sets it. If a detected press and a clearing write fall on the same edge, the press wins.
- R9: Offset 0x1C reads `sw_in` in bits [7:0], where a 1 means the switch is closed. Writes to it are ignored.
- R10: The word at 0x14 is read/write and drives `mst_wdata`. The word at 0x20 is read-only and captures `mst_rdata` on every edge where `mst_rvalid` is high.
- R11: The words at 0x24 and 0x28 are read/write and drive `mst_addr0` and `mst_addr1`.
- R12: Unmapped offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data (combinational) |
| btn_in | input | 1 | Raw push-button level |
| sw_in | input | 8 | Switch levels |
| mst_rdata | input | 32 | Data returned to a test master |
| mst_rvalid | input | 1 | Capture strobe for `mst_rdata` |
| led_out | output | 8 | LED drive |
| irq_out | output | 1 | Interrupt request (button flag) |
| osc_cfg | output | 57 | Three packed divisor words |
| mst_wdata | output | 32 | Test-master write data |
| mst_addr0 | output | 32 | Test-master address 0 |
| mst_addr1 | output | 32 | Test-master address 1 |

## Verification
Register writes appear on the outputs and in readback one edge after the access phase. Reads are valid within the access cycle itself. A button press reaches the flag on the third edge after the input moves. The bench's reference model keeps a three-deep history of sampled button levels to line up with that delay. It updates its register image on the same edge as the design and compares every output at the following falling edge. It compares read data at the falling edge inside each access phase.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int OSC_W = 19;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

  localparam logic [7:0] OFS_LOCK  = 8'h0C;
  localparam logic [7:0] OFS_LED   = 8'h10;
  localparam logic [7:0] OFS_WDAT  = 8'h14;
  localparam logic [7:0] OFS_BTN   = 8'h18;
  localparam logic [7:0] OFS_SW    = 8'h1C;
  localparam logic [7:0] OFS_RDAT  = 8'h20;
  localparam logic [7:0] OFS_MADR0 = 8'h24;
  localparam logic [7:0] OFS_MADR1 = 8'h28;

  // divisor reset: post-div 0, ref-div 22, vco-div 112
  function automatic logic [OSC_W-1:0] osc_reset();
    return {3'd0, 7'd22, 9'd112};
  endfunction

  function automatic logic key_ok(logic [15:0] d);
    return d == UNLOCK_KEY;
  endfunction
endpackage

// File: rtl/sysreg_osc.sv
module sysreg_osc #(
  parameter int N_OSC = 3,
  parameter int OSC_W = sysreg_pkg::OSC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lock_wr,
  input  logic [N_OSC-1:0]       osc_wr,
  input  logic [OSC_W-1:0]       wdata,
  output logic                   lock_open,
  output logic [N_OSC*OSC_W-1:0] osc_flat
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       lock_open <= 1'b0;
    else if (lock_wr) lock_open <= sysreg_pkg::key_ok(wdata[15:0]);

  for (genvar i = 0; i < N_OSC; i++) begin : g_osc
    logic [OSC_W-1:0] word;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                      word <= sysreg_pkg::osc_reset();
      else if (osc_wr[i] && lock_open) word <= wdata;
    assign osc_flat[i*OSC_W +: OSC_W] = word;
  end
endmodule

// File: rtl/sysreg_btn.sv
module sysreg_btn #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn,
  input  logic sw_wr,
  input  logic sw_val,
  output logic rise,
  output logic flag
);
  logic [SYNC:0] sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], btn};

  assign rise = sh[SYNC-1] & ~sh[SYNC];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     flag <= 1'b0;
    else if (rise)  flag <= 1'b1;
    else if (sw_wr) flag <= sw_val;
endmodule

// File: rtl/lockreg_file.sv
module lockreg_file #(
  parameter int          AW      = 8,
  parameter int          DW      = 32,
  parameter int          N_OSC   = 3,
  parameter int          LED_W   = 8,
  parameter int          SW_W    = 8,
  parameter int          SYNC    = 2,
  parameter logic [31:0] MADR0_RST = 32'h0400_0000,
  parameter logic [31:0] MADR1_RST = 32'h0400_0004
) (
  input  logic                    pclk,
  input  logic                    presetn,
  input  logic                    psel,
  input  logic                    penable,
  input  logic                    pwrite,
  input  logic [AW-1:0]           paddr,
  input  logic [DW-1:0]           pwdata,
  output logic [DW-1:0]           prdata,
  input  logic                    btn_in,
  input  logic [SW_W-1:0]         sw_in,
  input  logic [DW-1:0]           mst_rdata,
  input  logic                    mst_rvalid,
  output logic [LED_W-1:0]        led_out,
  output logic                    irq_out,
  output logic [N_OSC*sysreg_pkg::OSC_W-1:0] osc_cfg,
  output logic [DW-1:0]           mst_wdata,
  output logic [DW-1:0]           mst_addr0,
  output logic [DW-1:0]           mst_addr1
);
  import sysreg_pkg::*;
  localparam int LOCK_BIT = 16;

  logic             wr_any;
  logic [N_OSC-1:0] osc_wr;
  logic             lock_open;
  logic             btn_rise;
  logic             btn_flag;
  logic [DW-1:0]    rdat_q;

  assign wr_any = psel & penable & pwrite;

  for (genvar i = 0; i < N_OSC; i++) begin : g_dec
    assign osc_wr[i] = wr_any && (paddr == AW'(4 * i));
  end

  sysreg_osc #(.N_OSC(N_OSC), .OSC_W(OSC_W)) u_osc (
    .clk      (pclk),
    .rst_n    (presetn),
    .lock_wr  (wr_any && paddr == AW'(OFS_LOCK)),
    .osc_wr   (osc_wr),
    .wdata    (pwdata[OSC_W-1:0]),
    .lock_open(lock_open),
    .osc_flat (osc_cfg)
  );

  sysreg_btn #(.SYNC(SYNC)) u_btn (
    .clk   (pclk),
    .rst_n (presetn),
    .btn   (btn_in),
    .sw_wr (wr_any && paddr == AW'(OFS_BTN)),
    .sw_val(pwdata[0]),
    .rise  (btn_rise),
    .flag  (btn_flag)
  );
  assign irq_out = btn_flag;

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) begin
      led_out   <= '0;
      mst_wdata <= '0;
      mst_addr0 <= MADR0_RST;
      mst_addr1 <= MADR1_RST;
    end else if (wr_any) begin
      if (paddr == AW'(OFS_LED))   led_out   <= pwdata[LED_W-1:0];
      if (paddr == AW'(OFS_WDAT))  mst_wdata <= pwdata;
      if (paddr == AW'(OFS_MADR0)) mst_addr0 <= pwdata;
      if (paddr == AW'(OFS_MADR1)) mst_addr1 <= pwdata;
    end

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn)        rdat_q <= '0;
    else if (mst_rvalid) rdat_q <= mst_rdata;

  always_comb begin
    prdata = '0;
    for (int i = 0; i < N_OSC; i++)
      if (paddr == AW'(4 * i)) prdata = DW'(osc_cfg[i*OSC_W +: OSC_W]);
    case (paddr)
      AW'(OFS_LOCK):  prdata[LOCK_BIT] = ~lock_open;
      AW'(OFS_LED):   prdata = DW'(led_out);
      AW'(OFS_WDAT):  prdata = mst_wdata;
      AW'(OFS_BTN):   prdata = DW'(btn_flag);
      AW'(OFS_SW):    prdata = DW'(sw_in);
      AW'(OFS_RDAT):  prdata = rdat_q;
      AW'(OFS_MADR0): prdata = mst_addr0;
      AW'(OFS_MADR1): prdata = mst_addr1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sysreg_chk.sv
module sysreg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [7:0]  paddr,
  input logic [31:0] pwdata,
  input logic [56:0] osc_cfg,
  input logic        lock_open,
  input logic [7:0]  led_out,
  input logic        irq_out,
  input logic        btn_rise
);
  logic wr;
  assign wr = psel & penable & pwrite;

  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == 8'h0C && pwdata[15:0] == 16'hA05F) |=> lock_open);

  // R2
  key_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == 8'h0C && pwdata[15:0] != 16'hA05F) |=> !lock_open);

  // R4
  locked_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr < 8'h0C && !lock_open) |=> $stable(osc_cfg));

  // R6
  led_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == 8'h10) |=> led_out == $past(pwdata[7:0]));

  // R7
  press_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    btn_rise |=> irq_out);

  // R8
  clear_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == 8'h18 && !pwdata[0] && !btn_rise) |=> !irq_out);
endmodule

bind lockreg_file sysreg_chk u_chk (
  .clk      (pclk),
  .rst_n    (presetn),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pwdata   (pwdata),
  .osc_cfg  (osc_cfg),
  .lock_open(lock_open),
  .led_out  (led_out),
  .irq_out  (irq_out),
  .btn_rise (btn_rise)
);

// File: tb/sim_lockreg_file.sv
module sim_lockreg_file;
  logic        pclk = 0, presetn = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic        btn_in = 0;
  logic [7:0]  sw_in = 8'h00;
  logic [31:0] mst_rdata = 0;
  logic        mst_rvalid = 0;
  logic [7:0]  led_out;
  logic        irq_out;
  logic [56:0] osc_cfg;
  logic [31:0] mst_wdata, mst_addr0, mst_addr1;

  int errors = 0, checks = 0;

  always #4 pclk = ~pclk;

  lockreg_file u0 (.*);

  // reference model state
  logic [18:0] m_osc [3];
  bit          m_open;
  logic [7:0]  m_led;
  bit          m_flag;
  logic [31:0] m_wd, m_rd, m_a0, m_a1;
  bit          hist [$] = '{0, 0, 0};

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return {13'd0, m_osc[0]};
      8'h04: return {13'd0, m_osc[1]};
      8'h08: return {13'd0, m_osc[2]};
      8'h0C: return m_open ? 32'h0 : 32'h0001_0000;
      8'h10: return {24'd0, m_led};
      8'h14: return m_wd;
      8'h18: return {31'd0, m_flag};
      8'h1C: return {24'd0, sw_in};
      8'h20: return m_rd;
      8'h24: return m_a0;
      8'h28: return m_a1;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      for (int i = 0; i < 3; i++) m_osc[i] = 19'h02C70;
      m_open = 0; m_led = 0; m_flag = 0; m_wd = 0; m_rd = 0;
      m_a0 = 32'h0400_0000; m_a1 = 32'h0400_0004;
      hist = '{0, 0, 0};
    end else begin
      bit press;
      press = hist[1] && !hist[2];
      if (psel && penable && pwrite) begin
        case (paddr)
          8'h00, 8'h04, 8'h08: if (m_open) m_osc[paddr / 4] = pwdata[18:0];
          8'h0C: m_open = (pwdata[15:0] == 16'hA05F);
          8'h10: m_led = pwdata[7:0];
          8'h14: m_wd = pwdata;
          8'h18: m_flag = pwdata[0];
          8'h24: m_a0 = pwdata;
          8'h28: m_a1 = pwdata;
          default: ;
        endcase
      end
      if (press) m_flag = 1;
      if (mst_rvalid) m_rd = mst_rdata;
      hist.push_front(btn_in);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare outputs and read data on every falling edge
  always @(negedge pclk) if (presetn) begin
    chk("R1/R6 led_out", 64'(led_out), 64'(m_led));
    chk("R7/R8 irq_out", 64'(irq_out), 64'(m_flag));
    chk("R4/R5 osc_cfg", 64'(osc_cfg), 64'({m_osc[2], m_osc[1], m_osc[0]}));
    chk("R10 mst_wdata", 64'(mst_wdata), 64'(m_wd));
    chk("R11 mst_addr0", 64'(mst_addr0), 64'(m_a0));
    chk("R11 mst_addr1", 64'(mst_addr1), 64'(m_a1));
    if (psel && penable && !pwrite)
      chk($sformatf("R3/R9/R12 read @%h", paddr), 64'(prdata), 64'(m_read(paddr)));
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk) penable = 1;
    @(negedge pclk) begin psel = 0; penable = 0; pwrite = 0; end
  endtask

  task automatic rd(logic [7:0] a);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk) penable = 1;
    @(negedge pclk) begin psel = 0; penable = 0; end
  endtask

  task automatic rd_all();
    for (int a = 0; a <= 8'h30; a += 4) rd(8'(a));
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    sw_in = 8'hA5;
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);
    rd_all();                          // R1 reset values, R3 locked, R9
    wr(8'h00, 32'h0007_FFFF);          // R4 ignored while locked
    rd(8'h00);
    wr(8'h0C, 32'h0000_A05E);          // R2 wrong key
    wr(8'h04, 32'h1234);               // R4 still locked
    rd(8'h0C);
    wr(8'h0C, 32'hFFFF_A05F);          // R2 key in low half
    rd(8'h0C);                         // R3 unlocked reads 0
    wr(8'h00, 32'hFFFF_FFFF);          // R5 upper bits dropped
    wr(8'h04, 32'h0005_2C01);
    wr(8'h08, 32'h0001_0203);
    rd_all();
    wr(8'h0C, 32'h0);                  // R2 relock
    wr(8'h08, 32'h0);                  // R4 ignored
    rd(8'h08); rd(8'h0C);
    wr(8'h10, 32'hFFFF_FF3C);          // R6
    wr(8'h14, 32'hDEAD_BEEF);          // R10
    wr(8'h20, 32'h1111_1111);          // R10 read-only
    wr(8'h1C, 32'hFF);                 // R9 read-only
    wr(8'h24, 32'h8000_0010);          // R11
    wr(8'h28, 32'hC000_0020);
    wr(8'h34, 32'hFFFF_FFFF);          // R12 unmapped write
    mst_rdata = 32'hCAFE_F00D; mst_rvalid = 1;
    @(negedge pclk) mst_rvalid = 0;
    mst_rdata = 32'h0;
    sw_in = 8'h3C;
    rd_all();
    // R7 press held long sets once
    btn_in = 1;
    repeat (12) @(negedge pclk);
    wr(8'h18, 32'h0);                  // R8 clear while still held
    repeat (4) @(negedge pclk);
    rd(8'h18);
    btn_in = 0;
    repeat (4) @(negedge pclk);
    btn_in = 1;                        // R7 second press
    repeat (5) @(negedge pclk);
    rd(8'h18);
    btn_in = 0;
    wr(8'h18, 32'h0);                  // R8 clear
    rd(8'h18);
    wr(8'h18, 32'h1);                  // R8 software set
    rd(8'h18);
    wr(8'h18, 32'h0);
    repeat (4) @(negedge pclk);
    // R8 press and clear on the same edge: press wins
    btn_in = 1;
    @(negedge pclk);
    wr(8'h18, 32'h0);
    rd(8'h18);
    btn_in = 0;
    repeat (6) @(negedge pclk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule